// File: doc/BRIEF.md
# Arithmetic Compare and Test Execution Unit

This unit runs the compare-and-test instruction family of a wide-word processor. From a 3-bit function code it picks one of eight operations: compare the accumulator with an operand, pass a value through unchanged, add one, or subtract one. The operand comes from an immediate field or from a memory word. The unit tests the arithmetic result against zero under a 3-bit condition code. It then raises a skip request or a jump request, and marks the result for writing back to the accumulator or to memory.

A sequencer issues an instruction with a one-cycle `start` pulse while the unit is idle. Immediate forms finish on the next cycle. Memory forms wait for `mem_valid`. The unit stores the arriving word in its own operand register, so the memory bus is free for another fetch, and it finishes one cycle later. All outputs are meaningful only in the single cycle in which `done` is high. Program-counter update and memory sequencing belong to the caller.

Top module: `arith_test_unit`

## Requirements
- R1: After reset, `done`, `skip_req`, `jump_req`, `wr_acc` and `wr_mem` are low.
- R2: An accepted start with an immediate function (odd codes are memory forms, even codes are immediate) gives `done` high on the next cycle. A memory form gives no `done` until `mem_valid`, and then `done` on the following cycle. `done` lasts exactly one cycle.
- R3: A `start` that arrives while an instruction is in progress is ignored and does not change the instruction in flight.
- R4: Function 0 (immediate operand) and function 1 (memory operand) compute accumulator minus operand. The condition test uses the exact sign of the difference one bit wider than the data, so signed overflow never inverts the outcome.
- R5: Function 2 tests the accumulator unchanged, and function 3 tests the memory operand unchanged. Each returns the tested value as `result`.
- R6: Function 4 returns accumulator+1 and function 5 returns memory+1. Function 6 returns accumulator-1 and function 7 returns memory-1. All wrap at the data width, and the test is applied to the wrapped value.
- R7: Condition code 0 is never, 1 is less than zero, 2 is equal, 3 is less or equal, 4 is always, 5 is greater or equal, 6 is not equal, and 7 is greater. Codes 4 to 7 are the complements of codes 0 to 3.
- R8: When the condition holds, functions 2, 4 and 6 raise `jump_req`, and functions 0, 1, 3, 5 and 7 raise `skip_req`. `wr_acc` is high for functions 4 and 6, and `wr_mem` is high for functions 5 and 7.
- R9: Outside the `done` cycle, all request and write outputs are low. `skip_req` and `jump_req` are never high together.
- R10: The memory word is captured on the `mem_valid` cycle. Later changes on `mem_data` do not alter the result.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start | input | 1 | Issue an instruction (taken only when idle) |
| func | input | 3 | Function code |
| cond | input | 3 | Condition code |
| acc_in | input | DATA_W | Accumulator value |
| imm_in | input | DATA_W | Immediate operand |
| mem_valid | input | 1 | Memory word present on mem_data |
| mem_data | input | DATA_W | Memory operand word |
| done | output | 1 | One-cycle completion strobe |
| result | output | DATA_W | Arithmetic result (zero when not done) |
| skip_req | output | 1 | Skip the next instruction |
| jump_req | output | 1 | Take the jump |
| wr_acc | output | 1 | Write result to the accumulator |
| wr_mem | output | 1 | Write result to memory |

## Verification
The bench sweeps every function, condition, accumulator and operand value at a 4-bit width. This covers the signed corners where the difference overflows: a compare that tested the wrapped difference would give the wrong skip for pairs such as 7 against -8. The same sweep catches an increment or decrement that tests its value before wrapping, and a condition decoder that swaps two codes. Directed sequences issue a start during a memory wait, which a design without the busy guard would latch as a new instruction. They also change `mem_data` after capture, which exposes a design that reads the bus live instead of the held word.

// File: rtl/atu_pkg.sv
package atu_pkg;

   typedef enum logic [2:0] {
      FN_CMP_IMM  = 3'd0,
      FN_CMP_MEM  = 3'd1,
      FN_TST_ACC  = 3'd2,
      FN_TST_MEM  = 3'd3,
      FN_INC_ACC  = 3'd4,
      FN_INC_MEM  = 3'd5,
      FN_DEC_ACC  = 3'd6,
      FN_DEC_MEM  = 3'd7
   } atu_fn_e;

   typedef enum logic [1:0] {
      ALU_SUB  = 2'd0,
      ALU_PASS = 2'd1,
      ALU_INC  = 2'd2,
      ALU_DEC  = 2'd3
   } atu_alu_e;

   typedef enum logic [1:0] {
      ST_IDLE = 2'd0,
      ST_WAIT = 2'd1,
      ST_DONE = 2'd2
   } atu_state_e;

   typedef struct packed {
      logic     left_mem;   // left operand is the held operand word
      atu_alu_e alu;
      logic     exact;      // test the extended sign rather than the wrapped one
      logic     is_jump;
      logic     wr_acc;
      logic     wr_mem;
   } atu_ctl_t;

   function automatic logic atu_needs_mem(atu_fn_e fn);
      case (fn)
         FN_CMP_MEM, FN_TST_MEM, FN_INC_MEM, FN_DEC_MEM: return 1'b1;
         default:                                        return 1'b0;
      endcase
   endfunction

endpackage

// File: rtl/atu_decode.sv
module atu_decode
   import atu_pkg::*;
(
   input  atu_fn_e  fn,
   output atu_ctl_t ctl
);
   always_comb begin
      ctl          = '0;
      ctl.left_mem = 1'b0;
      ctl.alu      = ALU_PASS;
      case (fn)
         FN_CMP_IMM, FN_CMP_MEM: begin
            ctl.alu   = ALU_SUB;
            ctl.exact = 1'b1;
         end
         FN_TST_ACC: ctl.is_jump = 1'b1;
         FN_TST_MEM: ctl.left_mem = 1'b1;
         FN_INC_ACC: begin
            ctl.alu     = ALU_INC;
            ctl.is_jump = 1'b1;
            ctl.wr_acc  = 1'b1;
         end
         FN_INC_MEM: begin
            ctl.alu      = ALU_INC;
            ctl.left_mem = 1'b1;
            ctl.wr_mem   = 1'b1;
         end
         FN_DEC_ACC: begin
            ctl.alu     = ALU_DEC;
            ctl.is_jump = 1'b1;
            ctl.wr_acc  = 1'b1;
         end
         FN_DEC_MEM: begin
            ctl.alu      = ALU_DEC;
            ctl.left_mem = 1'b1;
            ctl.wr_mem   = 1'b1;
         end
         default: ctl = '0;
      endcase
   end
endmodule

// File: rtl/atu_alu.sv
module atu_alu
   import atu_pkg::*;
#(
   parameter int DATA_W = 36
) (
   input  logic [DATA_W-1:0] lhs,
   input  logic [DATA_W-1:0] rhs,
   input  atu_alu_e          op,
   input  logic              exact,
   output logic [DATA_W-1:0] res,
   output logic              neg,
   output logic              zero
);
   localparam int EXT_W = DATA_W + 1;

   generate
      if (DATA_W < 2) begin : g_bad_width
         $error("atu_alu: DATA_W must be at least 2");
      end
   endgenerate

   logic [EXT_W-1:0] lhs_x;
   logic [EXT_W-1:0] rhs_x;
   logic [EXT_W-1:0] diff;

   always_comb begin
      lhs_x = {lhs[DATA_W-1], lhs};
      case (op)
         ALU_SUB:  rhs_x = {rhs[DATA_W-1], rhs};
         ALU_INC:  rhs_x = '1;                       // minus one
         ALU_DEC:  rhs_x = EXT_W'(1);
         default:  rhs_x = '0;
      endcase
      diff = lhs_x - rhs_x;
      res  = diff[DATA_W-1:0];
      neg  = exact ? diff[EXT_W-1] : diff[DATA_W-1];
      zero = exact ? (diff == '0) : (diff[DATA_W-1:0] == '0);
   end
endmodule

// File: rtl/atu_cond.sv
module atu_cond (
   input  logic [2:0] cond,
   input  logic       neg,
   input  logic       zero,
   output logic       met
);
   logic base;
   always_comb begin
      case (cond[1:0])
         2'd0:    base = 1'b0;
         2'd1:    base = neg;
         2'd2:    base = zero;
         default: base = neg | zero;
      endcase
      met = base ^ cond[2];
   end
endmodule

// File: rtl/arith_test_unit.sv
module arith_test_unit
   import atu_pkg::*;
#(
   parameter int DATA_W = 36
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              start,
   input  logic [2:0]        func,
   input  logic [2:0]        cond,
   input  logic [DATA_W-1:0] acc_in,
   input  logic [DATA_W-1:0] imm_in,
   input  logic              mem_valid,
   input  logic [DATA_W-1:0] mem_data,
   output logic              done,
   output logic [DATA_W-1:0] result,
   output logic              skip_req,
   output logic              jump_req,
   output logic              wr_acc,
   output logic              wr_mem
);
   atu_state_e        state_q;
   atu_fn_e           fn_q;
   logic [2:0]        cond_q;
   logic [DATA_W-1:0] acc_q;
   logic [DATA_W-1:0] opnd_q;
   logic              busy;
   logic              waiting;

   atu_ctl_t          ctl;
   logic [DATA_W-1:0] left;
   logic [DATA_W-1:0] alu_res;
   logic              neg;
   logic              zero;
   logic              met;

   assign busy    = (state_q != ST_IDLE);
   assign waiting = (state_q == ST_WAIT);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state_q <= ST_IDLE;
         fn_q    <= FN_CMP_IMM;
         cond_q  <= '0;
         acc_q   <= '0;
         opnd_q  <= '0;
      end else begin
         case (state_q)
            ST_IDLE: if (start) begin
               fn_q    <= atu_fn_e'(func);
               cond_q  <= cond;
               acc_q   <= acc_in;
               opnd_q  <= imm_in;
               state_q <= atu_needs_mem(atu_fn_e'(func)) ? ST_WAIT : ST_DONE;
            end
            ST_WAIT: if (mem_valid) begin
               opnd_q  <= mem_data;
               state_q <= ST_DONE;
            end
            default: state_q <= ST_IDLE;
         endcase
      end
   end

   atu_decode u_decode (
      .fn  (fn_q),
      .ctl (ctl)
   );

   assign left = ctl.left_mem ? opnd_q : acc_q;

   atu_alu #(.DATA_W(DATA_W)) u_alu (
      .lhs   (left),
      .rhs   (opnd_q),
      .op    (ctl.alu),
      .exact (ctl.exact),
      .res   (alu_res),
      .neg   (neg),
      .zero  (zero)
   );

   atu_cond u_cond (
      .cond (cond_q),
      .neg  (neg),
      .zero (zero),
      .met  (met)
   );

   assign done     = (state_q == ST_DONE);
   assign result   = done ? alu_res : '0;
   assign skip_req = done & met & ~ctl.is_jump;
   assign jump_req = done & met &  ctl.is_jump;
   assign wr_acc   = done & ctl.wr_acc;
   assign wr_mem   = done & ctl.wr_mem;

endmodule

// File: rtl/atu_checker.sv
module atu_checker (
   input logic       clk,
   input logic       rst_n,
   input logic       start,
   input logic [2:0] func,
   input logic       mem_valid,
   input logic       busy,
   input logic       waiting,
   input logic       done,
   input logic       skip_req,
   input logic       jump_req,
   input logic       wr_acc,
   input logic       wr_mem
);
   p_quiet_r9: assert property (@(posedge clk) disable iff (!rst_n)
      !done |-> !(skip_req || jump_req || wr_acc || wr_mem));

   p_excl_req_r9: assert property (@(posedge clk) disable iff (!rst_n)
      !(skip_req && jump_req));

   p_one_write_r8: assert property (@(posedge clk) disable iff (!rst_n)
      !(wr_acc && wr_mem));

   p_imm_done_r2: assert property (@(posedge clk) disable iff (!rst_n)
      (start && !busy && !func[0]) |=> done);

   p_mem_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
      (start && !busy && func[0]) |=> !done);

   p_mem_done_r2: assert property (@(posedge clk) disable iff (!rst_n)
      (waiting && mem_valid) |=> done);

   p_pulse_r2: assert property (@(posedge clk) disable iff (!rst_n)
      done |=> !done);

   p_busy_ignore_r3: assert property (@(posedge clk) disable iff (!rst_n)
      (waiting && !mem_valid) |=> !done);
endmodule

bind arith_test_unit atu_checker u_atu_checker (
   .clk       (clk),
   .rst_n     (rst_n),
   .start     (start),
   .func      (func),
   .mem_valid (mem_valid),
   .busy      (busy),
   .waiting   (waiting),
   .done      (done),
   .skip_req  (skip_req),
   .jump_req  (jump_req),
   .wr_acc    (wr_acc),
   .wr_mem    (wr_mem)
);

// File: tb/test_arith_test_unit.sv
module test_arith_test_unit;
   localparam int W = 4;

   logic         clk = 1'b0;
   logic         rst_n = 1'b0;
   logic         start = 1'b0;
   logic [2:0]   func = '0;
   logic [2:0]   cond = '0;
   logic [W-1:0] acc_in = '0;
   logic [W-1:0] imm_in = '0;
   logic         mem_valid = 1'b0;
   logic [W-1:0] mem_data = '0;
   logic         done;
   logic [W-1:0] result;
   logic         skip_req, jump_req, wr_acc, wr_mem;

   int checks = 0;
   int errors = 0;

   always #4 clk = ~clk;

   arith_test_unit #(.DATA_W(W)) i_arith_test_unit (
      .clk, .rst_n, .start, .func, .cond, .acc_in, .imm_in,
      .mem_valid, .mem_data, .done, .result,
      .skip_req, .jump_req, .wr_acc, .wr_mem
   );

   function automatic int sx(logic [W-1:0] v);
      return v[W-1] ? int'(v) - (1 << W) : int'(v);
   endfunction

   function automatic int wrapv(int v);
      logic [W-1:0] t;
      t = v[W-1:0];
      return sx(t);
   endfunction

   task automatic check(bit ok, string tag, string what, int act, int exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s %s actual=%0h expected=%0h", tag, what, act, exp);
      end
   endtask

   task automatic run_op(int fn, int cd, logic [W-1:0] a_v, logic [W-1:0] o_v);
      int a, o, d;
      bit met, e_skip, e_jump, e_wa, e_wm, memf;
      string tag;
      a = sx(a_v);
      o = sx(o_v);
      case (fn)
         0, 1: d = a - o;
         2:    d = a;
         3:    d = o;
         4:    d = wrapv(a + 1);
         5:    d = wrapv(o + 1);
         6:    d = wrapv(a - 1);
         default: d = wrapv(o - 1);
      endcase
      case (cd % 4)
         0: met = 0;
         1: met = (d < 0);
         2: met = (d == 0);
         default: met = (d <= 0);
      endcase
      if (cd >= 4) met = !met;
      memf   = (fn % 2) == 1;
      e_jump = met && (fn == 2 || fn == 4 || fn == 6);
      e_skip = met && !(fn == 2 || fn == 4 || fn == 6);
      e_wa   = (fn == 4 || fn == 6);
      e_wm   = (fn == 5 || fn == 7);
      tag    = (fn < 2) ? "R4" : (fn < 4) ? "R5" : "R6";

      @(negedge clk);
      start  = 1'b1;
      func   = fn[2:0];
      cond   = cd[2:0];
      acc_in = a_v;
      imm_in = memf ? ~o_v : o_v;
      mem_data = memf ? ~o_v : o_v;
      @(negedge clk);
      start  = 1'b0;
      acc_in = ~a_v;
      imm_in = ~o_v;
      if (memf) begin
         check(done == 1'b0, "R2", "done before memory word", int'(done), 0);
         mem_valid = 1'b1;
         mem_data  = o_v;
         @(negedge clk);
         mem_valid = 1'b0;
         mem_data  = ~o_v;   // R10: bus change after capture
      end
      check(done == 1'b1, "R2", "done strobe", int'(done), 1);
      check(result == d[W-1:0], tag, "result", int'(result), int'(d[W-1:0]));
      check({skip_req, jump_req} == {e_skip, e_jump}, "R7", "skip/jump",
            int'({skip_req, jump_req}), int'({e_skip, e_jump}));
      check({wr_acc, wr_mem} == {e_wa, e_wm}, "R8", "writes",
            int'({wr_acc, wr_mem}), int'({e_wa, e_wm}));
      @(negedge clk);
      check(done == 1'b0, "R2", "done single cycle", int'(done), 0);
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      checks++;
      errors++;
      $display("FAIL watchdog expired actual=0 expected=1");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

   initial begin
      repeat (3) @(posedge clk);
      @(negedge clk);
      // R1: reset state
      check({done, skip_req, jump_req, wr_acc, wr_mem} == 5'b0, "R1", "reset outputs",
            int'({done, skip_req, jump_req, wr_acc, wr_mem}), 0);
      rst_n = 1'b1;

      // R3 / R9 / R10: start during memory wait is ignored
      @(negedge clk);
      start = 1'b1; func = 3'd3; cond = 3'd4; acc_in = 4'd0; imm_in = 4'd0;
      @(negedge clk);
      start = 1'b0;
      check({skip_req, jump_req, wr_acc, wr_mem} == 4'b0, "R9", "quiet while waiting",
            int'({skip_req, jump_req, wr_acc, wr_mem}), 0);
      start = 1'b1; func = 3'd4; cond = 3'd4; acc_in = 4'd5;
      @(negedge clk);
      start = 1'b0;
      check(done == 1'b0, "R3", "no done from ignored start", int'(done), 0);
      mem_valid = 1'b1; mem_data = 4'd5;
      @(negedge clk);
      mem_valid = 1'b0; mem_data = 4'd9;
      check(done == 1'b1, "R3", "original instruction completes", int'(done), 1);
      check(result == 4'd5, "R10", "held operand", int'(result), 5);
      check(skip_req == 1'b1 && jump_req == 1'b0, "R3", "skip kept from first start",
            int'({skip_req, jump_req}), 2);
      check(wr_acc == 1'b0, "R3", "no accumulator write from ignored start", int'(wr_acc), 0);
      @(negedge clk);

      // R4 overflow corner: 7 compared with -8 is greater
      run_op(0, 7, 4'd7, 4'd8);

      // exhaustive sweep: R4 R5 R6 R7 R8 R2 R10
      for (int fn = 0; fn < 8; fn++)
         for (int cd = 0; cd < 8; cd++)
            for (int av = 0; av < 16; av++)
               for (int ov = 0; ov < 16; ov++)
                  run_op(fn, cd, av[W-1:0], ov[W-1:0]);

      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end
endmodule